// File: doc/BRIEF.md
# Configurable GPIO Function Multiplexer

Four bidirectional general-purpose pins of a clock-management device are routed by this block. Each pin has a direction bit and a mode bit in a small register file. An output pin drives either a fixed device status signal or a software-written value. An input pin either steers a fixed device control select or is sampled into a readable register bit.

The block also exports a loss-of-lock status. That status has two qualification modes, chosen by a register bit. In the simple mode it clears as soon as the PLL reports lock. In the qualified mode it stays asserted until the PLL is locked and internal synchronization has also finished. The status pins pass through the block combinationally, so they show real-time status with no latching.

Register writes take effect on the next clock edge. Reads are combinational from the current address.

Top module: `gpio_func_mux`

## Requirements
- R1: After reset every pin is an input in fixed-function mode, all pad output enables are low, the output register reads 0 and the loss-of-lock mode is simple.
- R2: `pad_oe_o[k]` equals direction bit k (1 = output). A pin in input mode drives `pad_o[k]` low.
- R3: A pin that is an output in fixed-function mode (mode bit 0) drives these signals: pin 0 the holdover status, pin 1 `los_i[1]`, pin 2 `los_i[0]` and pin 3 the exported loss-of-lock. Each follows its status in the same cycle.
- R4: A pin that is an output in general-purpose mode (mode bit 1) drives bit k of the output register.
- R5: When pin 0 or pin 1 is an input in fixed-function mode, its pad level drives `out_sel_o[0]` or `out_sel_o[1]`. When pin 2 is an input in fixed-function mode, its pad level drives `clk_sel_o`. Each select reads 0 in any other configuration. Pin 3 has no fixed input function.
- R6: When a pin is an input in general-purpose mode, its pad level, delayed by a SYNC_STAGES-flop synchronizer, reads at bit 4+k of address 3. In any other configuration that bit reads 0.
- R7: With the mode bit (bit 0 of address 3) at 0, `lol_o` equals `pll_lol_i`.
- R8: With the mode bit at 1, `lol_o` is high while `pll_lol_i` or `sync_busy_i` is high.
- R9: The register map is as follows. Address 0 holds direction in bits 3:0. Address 1 holds mode in bits 3:0. Address 2 holds output values in bits 3:0. Address 3 holds the loss-of-lock mode in bit 0 and synchronized inputs in bits 7:4, with bits 3:1 reading 0. Writes land on the next edge, and writes to the read-only bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| pad_i | input | 4 | Pad input levels |
| pad_o | output | 4 | Pad output values |
| pad_oe_o | output | 4 | Pad output enables, high drives the pad |
| hold_i | input | 1 | PLL holdover status |
| los_i | input | 2 | Loss-of-signal per clock input |
| pll_lol_i | input | 1 | Raw PLL loss-of-lock |
| sync_busy_i | input | 1 | Internal synchronization in progress |
| out_sel_o | output | 2 | Output-select control from pins 1:0 |
| clk_sel_o | output | 1 | Clock-input select control from pin 2 |
| lol_o | output | 1 | Qualified loss-of-lock status |

## Verification
The bench builds the block with the default SYNC_STAGES of 2 and an 8-bit data width. At that depth the two-cycle lag of every general-purpose input is visible, and a pad that changes every cycle shows up in the readback. Random write traffic reaches every direction and mode combination on every pin. While it does, status inputs and pads toggle freely, so each fixed mapping, both loss-of-lock modes and the masking of unused selects are compared with the model on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PINS = 4;
  localparam int ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_MODE = 2'd1,
    ADDR_OUT  = 2'd2,
    ADDR_CTRL = 2'd3
  } reg_addr_e;

  // pin roles, fixed by the device pinout
  localparam int PIN_HOLD_OSEL0 = 0;
  localparam int PIN_LOS1_OSEL1 = 1;
  localparam int PIN_LOS0_CSEL  = 2;
  localparam int PIN_LOL        = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_lol_qual.sv
module gpio_lol_qual (
  input  logic lol_mode_i,
  input  logic pll_lol_i,
  input  logic sync_busy_i,
  output logic lol_o
);
  // qualified mode holds the alarm until synchronization settles too
  assign lol_o = pll_lol_i | (lol_mode_i & sync_busy_i);
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] gpi_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0] gpo_o,
  output logic                lol_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o      <= '0;
      mode_o     <= '0;
      gpo_o      <= '0;
      lol_mode_o <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_DIR:  dir_o      <= wdata_i[NUM_PINS-1:0];
        ADDR_MODE: mode_o     <= wdata_i[NUM_PINS-1:0];
        ADDR_OUT:  gpo_o      <= wdata_i[NUM_PINS-1:0];
        default:   lol_mode_o <= wdata_i[0];
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_DIR:  rdata_o[NUM_PINS-1:0] = dir_o;
      ADDR_MODE: rdata_o[NUM_PINS-1:0] = mode_o;
      ADDR_OUT:  rdata_o[NUM_PINS-1:0] = gpo_o;
      default: begin
        rdata_o[DATA_W-1 -: NUM_PINS] = gpi_i;
        rdata_o[0]                    = lol_mode_o;
      end
    endcase
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
(
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0] gpo_i,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] pad_sync_i,
  input  logic                hold_i,
  input  logic [1:0]          los_i,
  input  logic                lol_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] gpi_o,
  output logic [1:0]          out_sel_o,
  output logic                clk_sel_o
);
  logic [NUM_PINS-1:0] fixed_out;
  logic [NUM_PINS-1:0] fixed_in_en;

  always_comb begin
    fixed_out                 = '0;
    fixed_out[PIN_HOLD_OSEL0] = hold_i;
    fixed_out[PIN_LOS1_OSEL1] = los_i[1];
    fixed_out[PIN_LOS0_CSEL]  = los_i[0];
    fixed_out[PIN_LOL]        = lol_i;
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    assign pad_oe_o[k]    = dir_i[k];
    assign pad_o[k]       = dir_i[k] & (mode_i[k] ? gpo_i[k] : fixed_out[k]);
    assign gpi_o[k]       = ~dir_i[k] & mode_i[k] & pad_sync_i[k];
    assign fixed_in_en[k] = ~dir_i[k] & ~mode_i[k];
  end

  assign out_sel_o[0] = fixed_in_en[PIN_HOLD_OSEL0] & pad_i[PIN_HOLD_OSEL0];
  assign out_sel_o[1] = fixed_in_en[PIN_LOS1_OSEL1] & pad_i[PIN_LOS1_OSEL1];
  assign clk_sel_o    = fixed_in_en[PIN_LOS0_CSEL]  & pad_i[PIN_LOS0_CSEL];
endmodule

// File: rtl/gpio_func_mux.sv
module gpio_func_mux
  import gpio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic                hold_i,
  input  logic [1:0]          los_i,
  input  logic                pll_lol_i,
  input  logic                sync_busy_i,
  output logic [1:0]          out_sel_o,
  output logic                clk_sel_o,
  output logic                lol_o
);
  logic [NUM_PINS-1:0] dir, mode, gpo, pad_sync, gpi;
  logic                lol_mode;

  gpio_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .gpi_i(gpi), .rdata_o(reg_rdata_o),
    .dir_o(dir), .mode_o(mode), .gpo_o(gpo), .lol_mode_o(lol_mode)
  );

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pad_sync)
  );

  gpio_lol_qual u_lol (
    .lol_mode_i(lol_mode), .pll_lol_i, .sync_busy_i, .lol_o
  );

  gpio_pin_mux u_mux (
    .dir_i(dir), .mode_i(mode), .gpo_i(gpo), .pad_i, .pad_sync_i(pad_sync),
    .hold_i, .los_i, .lol_i(lol_o),
    .pad_o, .pad_oe_o, .gpi_o(gpi), .out_sel_o, .clk_sel_o
  );
endmodule

// File: rtl/gpio_func_mux_chk.sv
module gpio_func_mux_chk
  import gpio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [NUM_PINS-1:0] pad_i,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [1:0]          out_sel_o,
  input logic                clk_sel_o,
  input logic                lol_o,
  input logic                pll_lol_i
);
  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_DIR) |=> pad_oe_o == $past(reg_wdata_i[NUM_PINS-1:0]));

  assert_no_drive_when_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & ~pad_oe_o) == '0);

  assert_osel_from_pad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel_o & ~pad_i[1:0]) == 2'b00);

  assert_csel_from_pad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_o |-> pad_i[PIN_LOS0_CSEL]);

  assert_lol_not_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_lol_i |-> lol_o);
endmodule

bind gpio_func_mux gpio_func_mux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
  .out_sel_o(out_sel_o), .clk_sel_o(clk_sel_o), .lol_o(lol_o), .pll_lol_i(pll_lol_i)
);

// File: tb/tb_gpio_func_mux.sv
`timescale 1ns/1ps
module tb_gpio_func_mux;
  localparam int DW = 8;
  localparam int NS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] pad_in = '0, pad_out, pad_oe;
  logic       hold = 1'b0, plol = 1'b0, busy = 1'b0;
  logic [1:0] los = '0, osel;
  logic       csel, lol;

  int checks = 0, errors = 0;

  gpio_func_mux #(.DATA_W(DW), .SYNC_STAGES(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .hold_i(hold), .los_i(los), .pll_lol_i(plol),
    .sync_busy_i(busy), .out_sel_o(osel), .clk_sel_o(csel), .lol_o(lol)
  );

  always #10 clk = ~clk;

  // reference state
  int m_dir, m_mode, m_gpo, m_lolm;
  int hist[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dir = 0; m_mode = 0; m_gpo = 0; m_lolm = 0;
    hist.delete();
    for (int i = 0; i < NS; i++) hist.push_back(0);
  endtask

  task automatic model_edge();
    if (!rst_n) begin model_reset(); return; end
    hist.push_front(int'(pad_in));
    void'(hist.pop_back());
    if (we) begin
      case (addr)
        2'd0: m_dir  = wdata[3:0];
        2'd1: m_mode = wdata[3:0];
        2'd2: m_gpo  = wdata[3:0];
        default: m_lolm = wdata[0];
      endcase
    end
  endtask

  task automatic compare();
    int exp_lol, fixed, exp_po, exp_sel, exp_cs, gpi, exp_rd;
    exp_lol = m_lolm ? int'(plol | busy) : int'(plol);
    chk(lol == exp_lol, m_lolm ? "R8 lol" : "R7 lol", lol, exp_lol);
    chk(pad_oe == m_dir[3:0], "R2 oe", pad_oe, m_dir);
    fixed = {exp_lol[0], los[0], los[1], hold};
    exp_po = m_dir & ((m_mode & m_gpo) | (~m_mode & fixed)) & 4'hF;
    chk(pad_out == exp_po[3:0], (m_dir & m_mode) != 0 ? "R4 pad_o" : "R3 pad_o",
        pad_out, exp_po);
    exp_sel = pad_in[1:0] & ~m_dir[1:0] & ~m_mode[1:0];
    exp_cs  = pad_in[2] & ~m_dir[2] & ~m_mode[2];
    chk(osel == exp_sel[1:0] && csel == exp_cs[0], "R5 sel",
        {osel, csel}, {exp_sel[1:0], exp_cs[0]});
    gpi = hist[NS-1] & ~m_dir & m_mode & 4'hF;
    case (addr)
      2'd0: exp_rd = m_dir;
      2'd1: exp_rd = m_mode;
      2'd2: exp_rd = m_gpo;
      default: exp_rd = (gpi << 4) | m_lolm;
    endcase
    chk(rdata == exp_rd[7:0], addr == 2'd3 ? "R6 rdata" : "R9 rdata", rdata, exp_rd);
  endtask

  task automatic drive_rand(input bit allow_wr);
    pad_in = 4'($urandom);
    hold   = 1'($urandom);
    los    = 2'($urandom);
    plol   = 1'($urandom);
    busy   = 1'($urandom);
    addr   = 2'($urandom);
    we     = allow_wr && ($urandom % 5 == 0);
    wdata  = 8'($urandom);
  endtask

  task automatic cycle(input bit allow_wr);
    @(posedge clk);
    model_edge();
    #5 drive_rand(allow_wr);
    #10 compare();
  endtask

  initial begin
    model_reset();
    #15;
    pad_in = 4'b0111;
    addr = 2'd3;
    #1;
    // R1: reset state
    chk(pad_oe == 4'h0, "R1 oe", pad_oe, 0);
    chk(osel == 2'b11 && csel == 1'b1, "R1 fixed-in", {osel, csel}, 3'b111);
    chk(rdata == 8'h00, "R1 ctrl", rdata, 0);
    addr = 2'd2; #1;
    chk(rdata == 8'h00, "R1 gpo", rdata, 0);
    plol = 1'b0; busy = 1'b1; #1;
    chk(lol == 1'b0, "R1 lol simple", lol, 0);
    repeat (2) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (10) cycle(1'b0);
    repeat (600) cycle(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule